// File: doc/BRIEF.md
# Processor Bus Register Bridge

This block is a synchronous slave for an asynchronous processor bus. The bus carries an active-low chip select, an active-low data strobe, a read/write line and an address. The data bus is presented as a separate input, output and output enable, and the pad ring forms the tri-state driver. Behind the bridge sits a small register file that belongs to a recovered clock domain. That domain can pause for a few cycles, so every access is qualified by a heartbeat: a toggle flag sent from the target domain.

Chip select and strobe pass through two-flop synchronisers. An access begins on the first synchronised cycle in which both are low and at least one of them was high in the cycle before. The bridge then waits a fixed, parameterised number of margin cycles and performs the read or the write. It drives read data until the strobe is seen high again. If the heartbeat has stopped during the access, a read returns the last value captured and a write is dropped.

Top module: `procbus_regbridge`

## Requirements
- R1: After reset, `dat_oe` is 0, `dat_o` is 0 and every register reads back as 0.
- R2: A write with `rnw`=0 to an address below 16 stores `dat_i` in that register. A later read with `rnw`=1 of the same address returns the stored value, and the other registers are not disturbed.
- R3: For a read, `dat_oe` is 1 and `dat_o` holds the addressed value from the (4+MARGIN)-th rising clock edge after `ds_n` falls (the 7th with the default MARGIN of 3).
- R4: `dat_oe` returns to 0 by the 3rd rising edge after the strobe is released, and stays 0 for the whole of a write access.
- R5: If the heartbeat `tgt_tog` has not changed for STALL_LIM (2) host cycles at any point during a read, the read returns the value captured by the previous read.
- R6: If the heartbeat has stalled during a write, the target register keeps its old value.
- R7: A strobe asserted while `cs_n` is high starts no access, and a write made that way has no effect.
- R8: A strobe released before the access point (4+MARGIN edges) has no effect.
- R9: Exactly one access is made per strobe assertion. Changes of `dat_i` after the access point are ignored. A new access needs the strobe to be seen high for at least one synchronised cycle first.
- R10: Addresses 16 and above are unmapped: reads return 0, and writes change no register, including the register whose index equals the low four address bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| rnw | input | 1 | 1 = read, 0 = write; held while strobe low |
| addr | input | AW (5) | Register address |
| dat_i | input | DW (8) | Write data from the processor |
| dat_o | output | DW (8) | Read data toward the pad |
| dat_oe | output | 1 | Pad output enable (1 = drive bus) |
| tgt_tog | input | 1 | Heartbeat toggle from the target clock domain |

## Verification
A bad access state shows at the ports within one strobe. If the counter is wrong, the 7th-edge sample of `dat_o` is stale or `dat_oe` is still low. A sticky or missing stall flag is seen on the next read-back, either as a changed register or as a fresh value where the previous read was due. A start detector that ignores the idle requirement, or that does not check chip select, leaves a wrong register value that the directed read-back that follows shows. A release path that hangs keeps `dat_oe` high past the third edge after the strobe is released.

// File: rtl/procbus_regbridge.sv
module procbus_regbridge #(
  parameter int AW        = 5,
  parameter int DW        = 8,
  parameter int NREG      = 16,
  parameter int MARGIN    = 3,
  parameter int STALL_LIM = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          ds_n,
  input  logic          rnw,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dat_i,
  output logic [DW-1:0] dat_o,
  output logic          dat_oe,
  input  logic          tgt_tog
);
  localparam int IW  = $clog2(NREG);
  localparam int CW  = $clog2(MARGIN + 2);
  localparam int GW  = $clog2(STALL_LIM + 2);
  localparam logic [1:0] IDLE = 2'd0, ACC = 2'd1, DRV = 2'd2;

  logic            cs1, cs2, ds1, ds2, sel_q;
  logic [2:0]      tg;
  logic [GW-1:0]   age;
  logic [1:0]      st;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   a_q;
  logic            rw_q, stall_q;
  logic [DW-1:0]   rd_q;
  logic [NREG-1:0][DW-1:0] regs;

  wire sel_s  = !cs2 && !ds2;
  wire start  = (st == IDLE) && sel_s && !sel_q;
  wire alive  = age < GW'(STALL_LIM);
  wire fire   = (st == ACC) && sel_s && (cnt == '0);
  wire ok     = fire && alive && !stall_q;
  wire mapped = {{(32-AW){1'b0}}, a_q} < 32'(NREG);

  assign dat_o  = rd_q;
  assign dat_oe = rw_q && (st != IDLE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {cs1, cs2, ds1, ds2} <= 4'hF;
      sel_q <= 1'b0;
      tg    <= '0;
      age   <= '0;
    end else begin
      cs1   <= cs_n;  cs2 <= cs1;
      ds1   <= ds_n;  ds2 <= ds1;
      sel_q <= sel_s;
      tg    <= {tg[1:0], tgt_tog};
      if (tg[2] != tg[1])       age <= '0;
      else if (!age[GW-1])      age <= age + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      a_q     <= '0;
      rw_q    <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      case (st)
        IDLE: if (start) begin
          st      <= ACC;
          cnt     <= CW'(MARGIN);
          a_q     <= addr;
          rw_q    <= rnw;
          stall_q <= 1'b0;
        end
        ACC: begin
          stall_q <= stall_q || !alive;
          if (!sel_s)           st <= IDLE;
          else if (cnt == '0)   st <= DRV;
          else                  cnt <= cnt - 1'b1;
        end
        default: if (!sel_s) st <= IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_q <= '0;
      regs <= '0;
    end else if (ok) begin
      if (rw_q)
        rd_q <= mapped ? regs[a_q[IW-1:0]] : '0;
      else if (mapped)
        regs[a_q[IW-1:0]] <= dat_i;
    end
endmodule

module procbus_regbridge_chk #(
  parameter int DW   = 8,
  parameter int NREG = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cs2,
  input logic                    ds2,
  input logic                    alive,
  input logic [1:0]              st,
  input logic                    dat_oe,
  input logic [DW-1:0]           dat_o,
  input logic [NREG-1:0][DW-1:0] regs
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> (!dat_oe && dat_o == '0));
  // R5
  stall_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !alive |=> $stable(dat_o));
  // R6
  stall_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) !alive |=> $stable(regs));
  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n) (ds2 && $past(ds2)) |-> !dat_oe);
  // R7
  cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) (st == 2'd0 && cs2) |=> st == 2'd0);
  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n) (st == 2'd1 && ds2) |=> st == 2'd0);
endmodule

bind procbus_regbridge procbus_regbridge_chk #(.DW(DW), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs2(cs2), .ds2(ds2), .alive(alive),
  .st(st), .dat_oe(dat_oe), .dat_o(dat_o), .regs(regs)
);

// File: tb/tb_procbus_regbridge.sv
module tb_procbus_regbridge;
  logic       clk = 0, rst_n = 0;
  logic       cs_n = 1, ds_n = 1, rnw = 1, tgt_tog = 0, tgt_run = 1;
  logic [4:0] addr = '0;
  logic [7:0] dat_i = '0;
  logic [7:0] dat_o;
  logic       dat_oe;
  int         total = 0, fails = 0;
  logic       done = 0;

  always #10 clk = ~clk;
  always @(negedge clk) if (tgt_run) tgt_tog <= ~tgt_tog;

  procbus_regbridge dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds_n(ds_n), .rnw(rnw),
    .addr(addr), .dat_i(dat_i), .dat_o(dat_o), .dat_oe(dat_oe), .tgt_tog(tgt_tog)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic do_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rnw = 1; cs_n = 0; ds_n = 0;
    repeat (7) @(negedge clk);
    check("R3 oe at access point", {7'b0, dat_oe}, 8'd1);
    d = dat_o;
    repeat (3) @(negedge clk);
    cs_n = 1; ds_n = 1;
    repeat (3) @(negedge clk);
    check("R4 released", {7'b0, dat_oe}, 8'd0);
  endtask

  task automatic do_write(input logic [4:0] a, input logic [7:0] d, input int len, input logic csn);
    @(negedge clk);
    addr = a; rnw = 0; dat_i = d; cs_n = csn; ds_n = 0;
    repeat (len) @(negedge clk);
    if (len >= 8) check("R4 no drive on write", {7'b0, dat_oe}, 8'd0);
    cs_n = 1; ds_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 oe after reset", {7'b0, dat_oe}, 8'd0);
    check("R1 data after reset", dat_o, 8'h00);
    for (int i = 0; i < 16; i += 5) begin
      do_read(5'(i), d);
      check("R1 register cleared", d, 8'h00);
    end
  endtask

  task automatic t_patterns;
    logic [7:0] d;
    do_write(5'd0, 8'hFF, 10, 0);
    do_write(5'd15, 8'hA5, 10, 0);
    do_read(5'd0, d);  check("R2 all ones", d, 8'hFF);
    do_read(5'd15, d); check("R2 alternating", d, 8'hA5);
    for (int i = 1; i < 15; i++) do_write(5'(i), 8'(i * 17 + 3), 9, 0);
    for (int i = 1; i < 15; i++) begin
      do_read(5'(i), d);
      check("R2 sweep", d, 8'(i * 17 + 3));
    end
    do_read(5'd0, d); check("R2 neighbour untouched", d, 8'hFF);
  endtask

  task automatic t_latency;
    @(negedge clk);
    addr = 5'd15; rnw = 1; cs_n = 0; ds_n = 0;
    repeat (7) @(negedge clk);
    check("R3 value at 7th edge", dat_o, 8'hA5);
    check("R3 driven at 7th edge", {7'b0, dat_oe}, 8'd1);
    repeat (2) @(negedge clk);
    cs_n = 1; ds_n = 1;
    repeat (2) @(negedge clk);
    check("R4 still driven 2 edges after release", {7'b0, dat_oe}, 8'd1);
    @(negedge clk);
    check("R4 off at 3rd edge", {7'b0, dat_oe}, 8'd0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_stall;
    logic [7:0] d;
    do_write(5'd3, 8'h5A, 10, 0);
    do_write(5'd7, 8'h33, 10, 0);
    do_read(5'd3, d); check("R5 setup read", d, 8'h5A);
    tgt_run = 0; repeat (8) @(negedge clk);
    do_read(5'd7, d); check("R5 stalled read gives previous", d, 8'h5A);
    do_write(5'd3, 8'hFF, 10, 0);
    tgt_run = 1; repeat (8) @(negedge clk);
    do_read(5'd3, d); check("R6 stalled write dropped", d, 8'h5A);
    do_read(5'd7, d); check("R5 resumed read fresh", d, 8'h33);
  endtask

  task automatic t_cs_gate;
    logic [7:0] d;
    do_write(5'd1, 8'h99, 10, 1);
    do_read(5'd1, d); check("R7 cs high ignored", d, 8'(1 * 17 + 3));
  endtask

  task automatic t_short;
    logic [7:0] d;
    do_write(5'd2, 8'hC3, 3, 0);
    do_read(5'd2, d); check("R8 short strobe ignored", d, 8'(2 * 17 + 3));
  endtask

  task automatic t_single;
    logic [7:0] d;
    @(negedge clk);
    addr = 5'd4; rnw = 0; dat_i = 8'h11; cs_n = 0; ds_n = 0;
    repeat (8) @(negedge clk);
    dat_i = 8'h22;
    repeat (6) @(negedge clk);
    cs_n = 1; ds_n = 1;
    repeat (3) @(negedge clk);
    do_read(5'd4, d); check("R9 one access per strobe", d, 8'h11);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    do_write(5'd20, 8'h77, 10, 0);
    do_read(5'd20, d); check("R10 unmapped reads zero", d, 8'h00);
    do_read(5'd4, d);  check("R10 no alias write", d, 8'h11);
    do_read(5'd31, d); check("R10 top address zero", d, 8'h00);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_patterns();
    t_latency();
    t_stall();
    t_cs_gate();
    t_short();
    t_single();
    t_unmapped();
    done = 1;
    report();
  end
endmodule